// File: doc/BRIEF.md
# Posit to single-precision converter

This unit takes one posit word of a configurable width (up to 16 bits) with zero, one or two exponent bits and returns the IEEE-754 single-precision value it stands for. Negative words are first negated to recover the magnitude. A run-length search over the regime then fixes where the exponent and fraction fields begin, so the fraction width changes from one word to the next.

Words enter and results leave through valid/ready handshakes. An accepted word appears as a registered result on the following cycle. A new word can be taken in every cycle in which the output register is empty or being drained. For every supported width, the converted value fits the single-precision normal range and mantissa, so no rounding or saturation is ever needed.

Top module: `posit_to_fp32`

## Requirements
- R1: The all-zero posit converts to 0x00000000.
- R2: The posit with only its most significant bit set (not-a-real) converts to the quiet NaN 0x7FC00000.
- R3: Any other posit with its top bit set produces bit 31 = 1, and bits 30:0 equal those of its two's-complement negation.
- R4: For a positive word, a leading run of m identical bits below the sign gives k = m − 1 for ones and k = −m for zeros; the result's bits 30:23 equal k·2^ES + e + 127, with e the ES bits after the stop bit.
- R5: Exponent bits that fall past the end of the word, because the regime fills it, count as zeros.
- R6: The fraction bits left after sign, regime, stop bit and exponent appear left-aligned in result bits 22:0, and all bits below them are zero; in particular, bits 23−NBITS:0 are always zero.
- R7: in_ready is high whenever out_valid is low or out_ready is high. A word accepted on a clock edge (in_valid and in_ready both high) makes out_valid high after that edge.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_fp does not change.
- R9: After reset, out_valid is low and in_ready is high.
- R10: Results leave in the order the words were accepted, exactly one per accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Unit can take a word this cycle |
| in_posit | input | NBITS | Posit word |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_fp | output | 32 | Single-precision result |

## Verification
Each posit code of an 8-bit format with two exponent bits, and of a 16-bit format with one exponent bit, is fed in ascending order. The codes are compared with an integer bit-walking model. This sweep separates the zero and not-a-real codes, negative words, short and long regime runs of both polarities, and words whose regime leaves no room for some or all exponent bits. Random gaps on the input and random back-pressure on the output check that results are neither lost, duplicated, reordered nor altered while stalled.

// File: rtl/posit_to_fp32.sv
module posit_to_fp32 #(
  parameter int NBITS = 16,
  parameter int ES    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [NBITS-1:0] in_posit,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_fp
);
  localparam int BW = NBITS - 1;
  localparam int CW = $clog2(NBITS) + 1;
  localparam logic [NBITS-1:0] NAR = {1'b1, {BW{1'b0}}};

  logic             sgn, r0, is_zero, is_nar;
  logic [NBITS-1:0] mag;
  logic [BW-1:0]    body, scan, rest, frac;
  logic [CW-1:0]    run;
  logic [2:0]       ev;
  logic signed [9:0] kval, scale;
  logic [7:0]       bexp;
  logic [22:0]      mant;
  logic [31:0]      result;

  assign sgn     = in_posit[NBITS-1];
  assign mag     = sgn ? (~in_posit + 1'b1) : in_posit;
  assign body    = mag[BW-1:0];
  assign r0      = body[BW-1];
  assign scan    = r0 ? ~body : body;
  assign is_zero = (in_posit == '0);
  assign is_nar  = (in_posit == NAR);

  always_comb begin
    run = CW'(BW);
    for (int i = 0; i < BW; i++)
      if (scan[i]) run = CW'(BW - 1 - i);
  end

  assign rest = body << (run + 1'b1);

  generate
    if (ES > 0) begin : g_exp
      assign ev = 3'(rest[BW-1 -: ES]);
    end else begin : g_noexp
      assign ev = '0;
    end
  endgenerate

  assign frac = rest << ES;

  always_comb begin
    kval  = r0 ? ($signed(10'(run)) - 10'sd1) : -$signed(10'(run));
    scale = (kval <<< ES) + $signed(10'(ev));
  end

  assign bexp = 8'(scale + 10'sd127);
  assign mant = 23'(frac) << (23 - BW);

  assign result = is_zero ? 32'h0000_0000 :
                  is_nar  ? 32'h7FC0_0000 :
                            {sgn, bexp, mant};

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fp    <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (in_valid && in_ready) out_fp <= result;
    end
  end
endmodule

module posit_to_fp32_chk #(
  parameter int NBITS = 16,
  parameter int ES    = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [NBITS-1:0] in_posit,
  input logic             out_valid,
  input logic             out_ready,
  input logic [31:0]      out_fp
);
  localparam logic [NBITS-1:0] NAR = {1'b1, {(NBITS-1){1'b0}}};
  localparam logic [31:0] LOWMASK = 32'((64'd1 << (24 - NBITS)) - 64'd1);

  // R1
  zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_posit == '0 |=> out_fp == 32'h0);
  // R2
  nar_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_posit == NAR |=> out_fp == 32'h7FC0_0000);
  // R3
  neg_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_posit[NBITS-1] && in_posit != NAR |=> out_fp[31]);
  // R6
  low_mant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_fp & LOWMASK) == 32'h0);
  // R7
  ready_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid || out_ready |-> in_ready);
  // R7
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_fp));
endmodule

bind posit_to_fp32 posit_to_fp32_chk #(.NBITS(NBITS), .ES(ES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_posit(in_posit), .out_valid(out_valid), .out_ready(out_ready),
  .out_fp(out_fp)
);

// File: tb/tb_posit_to_fp32.sv
module tb_lane #(
  parameter int N  = 8,
  parameter int ES = 0
) (
  input  logic clk,
  input  logic rst_n,
  output logic done,
  output int   checks,
  output int   errors
);
  localparam int TOTAL = 1 << N;

  logic         in_valid, in_ready, out_valid, out_ready;
  logic [N-1:0] in_posit;
  logic [31:0]  out_fp;

  posit_to_fp32 #(.NBITS(N), .ES(ES)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_posit(in_posit), .out_valid(out_valid), .out_ready(out_ready),
    .out_fp(out_fp)
  );

  logic [31:0] exp_q[$];
  string       tag_q[$];
  int          idx = 0;
  logic        started = 0, stall_prev = 0;
  logic [31:0] held = 0;

  function automatic logic [31:0] ref_fp(input int w, output string tag);
    int m, pos, cnt, k, e, fb, f, scale, first;
    bit s, cut;
    cut = 0;
    if (w == 0) begin tag = "R1"; return 32'h0; end
    if (w == (1 << (N-1))) begin tag = "R2"; return 32'h7FC0_0000; end
    s = w[N-1];
    m = s ? ((-w) & (TOTAL - 1)) : w;
    pos = N - 2;
    first = (m >> pos) & 1;
    cnt = 0;
    while (pos >= 0 && ((m >> pos) & 1) == first) begin cnt++; pos--; end
    pos--;
    k = first ? cnt - 1 : -cnt;
    e = 0;
    for (int j = 0; j < ES; j++) begin
      e = e << 1;
      if (pos >= 0) begin e = e | ((m >> pos) & 1); pos--; end
      else cut = 1;
    end
    fb = (pos + 1 > 0) ? pos + 1 : 0;
    f = m & ((1 << fb) - 1);
    scale = k * (1 << ES) + e;
    tag = s ? "R3" : (cut ? "R5" : "R4/R6");
    return {s, 8'(scale + 127), 23'(f << (23 - fb))};
  endfunction

  initial begin
    done = 0; checks = 0; errors = 0;
    in_valid = 0; in_posit = '0; out_ready = 0;
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (!started) begin
        started = 1;
        checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
          errors++;
          $display("FAIL R9 out_valid=%0b in_ready=%0b expected 0 1", out_valid, in_ready);
        end
      end
      if (stall_prev) begin
        checks++;
        if (!(out_valid && out_fp == held)) begin
          errors++;
          $display("FAIL R8 valid=%0b data=%08h expected 1 %08h", out_valid, out_fp, held);
        end
      end
      out_ready = ($urandom % 4) != 0;
      in_valid  = (idx < TOTAL) && (($urandom % 8) != 0);
      in_posit  = N'(idx);
      #1;
      if (!out_valid || out_ready) begin
        checks++;
        if (!in_ready) begin
          errors++;
          $display("FAIL R7 in_ready=0 expected 1");
        end
      end
      if (out_valid && out_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R10 unexpected result %08h expected none", out_fp);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (out_fp !== e) begin
            errors++;
            $display("FAIL %s N=%0d ES=%0d out=%08h expected %08h", t, N, ES, out_fp, e);
          end
        end
      end
      stall_prev = out_valid && !out_ready;
      held = out_fp;
      if (in_valid && in_ready) begin
        string t;
        logic [31:0] r;
        r = ref_fp(idx, t);
        exp_q.push_back(r);
        tag_q.push_back(t);
        idx++;
      end
      if (idx == TOTAL && exp_q.size() == 0) done = 1;
    end
  end
endmodule

module tb_posit_to_fp32;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 190000;

  logic clk = 0;
  logic rst_n = 0;
  logic done8, done16;
  int   c8, e8, c16, e16;

  always #(CLK_PERIOD/2) clk = ~clk;

  tb_lane #(.N(8),  .ES(2)) lane8  (.clk(clk), .rst_n(rst_n), .done(done8),  .checks(c8),  .errors(e8));
  tb_lane #(.N(16), .ES(1)) lane16 (.clk(clk), .rst_n(rst_n), .done(done16), .checks(c16), .errors(e16));

  initial begin
    int cycles, wd;
    wd = 0;
    cycles = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    while (!(done8 && done16) && cycles < LIMIT) begin
      @(posedge clk);
      cycles++;
    end
    if (!(done8 && done16)) begin
      wd = 1;
      $display("FAIL R10 watchdog expired after %0d cycles expected completion", cycles);
    end
    repeat (2) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", c8 + c16 + wd, e8 + e16 + wd);
    $finish;
  end
endmodule